// File: doc/BRIEF.md
# Audio Receiver Control and Interrupt Register Block

This block is the bus-facing control side of a receiver for a bi-phase coded digital audio stream. A bus master reaches it over a simple Wishbone-style single-word interface. The block holds a fixed version word, a configuration word, a live status word, an interrupt enable mask and an interrupt flag word. It also maps a sample store into the upper half of the same register space.

On the core side it takes a lock indication and a sample-valid strobe with its data word from the line decoder. Captured samples fill the store as a ping-pong buffer. When the lower half fills, the block raises one event, and when the upper half fills it raises another. Each event, and each new lock, sets a sticky flag. Software clears a flag by writing a one to it. A single level interrupt output stays high while any enabled flag is set.

Top module: `audio_rx_regs`

## Requirements
- R1: A read at word offset 0x00 returns the version constant, 0x0101 by default.
- R2: Each access (cyc and stb both high while ack is low) gets exactly one ack pulse, one cycle wide, in the next cycle. Read data is valid in the ack cycle, and ack never rises without a request.
- R3: Offset 0x01 (configuration) stores bits 2:0 of a write and reads back only those bits. Bit 0 enables the receiver, bit 1 enables capture, and bit 2 is a plain stored flag.
- R4: Offset 0x02 (status) reads 1 in bit 0 only while the receiver is enabled and the lock input is high. Otherwise it reads 0.
- R5: A rising edge of the status lock bit sets flag bit 0 at offset 0x04, even while its mask bit is clear. Setting the mask bit afterwards raises the interrupt at once.
- R6: A write to offset 0x04 clears each flag whose write bit is 1 and leaves the flags written with 0 unchanged.
- R7: `irq` is high exactly while some flag bit and the same bit of the mask at offset 0x03 are both 1. With the mask at zero, `irq` stays low.
- R8: While configuration bits 0 and 1 are both set, each sample strobe stores its data word at the write pointer and advances it. A store at entry k reads back at offset 0x80+k. With capture off, strobes store nothing.
- R9: The store that fills entry 63 sets flag bit 1 (lower half full), and the store that fills entry 127 sets flag bit 2 (upper half full). No flag is set earlier.
- R10: The write pointer returns to entry 0 whenever capture is off. After entry 127 it wraps to entry 0.
- R11: Writes to the version, status and sample-window offsets change nothing. Reads of unused offsets below 0x80 return 0.
- R12: Synchronous active-low reset clears configuration, mask, flags, `ack`, read data and `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_cyc | input | 1 | Bus cycle valid |
| bus_stb | input | 1 | Bus strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_adr | input | AW (8) | Word offset |
| bus_wdat | input | DW (16) | Write data |
| bus_ack | output | 1 | Access acknowledge |
| bus_rdat | output | DW (16) | Read data, valid with ack |
| irq | output | 1 | Level interrupt |
| lock_in | input | 1 | Decoder lock indication |
| smp_valid | input | 1 | One-cycle sample strobe |
| smp_data | input | DW (16) | Sample word |

## Verification
The bench goes after the half-full boundaries. A design with an off-by-one pointer compare would flag the lower or upper half one sample early or late, and the bench checks the flags after 63, 64, 127 and 128 samples. It checks that a lock flag is recorded while masked and then raises `irq` when the mask is set later. A design that gates the flag with the mask would stay silent there. It also checks that a write-one-clear with zero bits leaves flags standing, and that turning capture off rewinds the pointer, so that a design that only wrapped at the top would put the next sample in the wrong entry. Writes to read-only offsets and the sample window are read back to prove they changed nothing.

// File: rtl/arx_pkg.sv
// Package: shared offsets and bit positions of the audio receiver register block.
// Assumes word addressing; the sample window occupies the upper half of the space.
package arx_pkg;
    localparam int OFS_VER  = 0;
    localparam int OFS_CFG  = 1;
    localparam int OFS_STAT = 2;
    localparam int OFS_MASK = 3;
    localparam int OFS_FLAG = 4;

    localparam int CFG_EN   = 0;
    localparam int CFG_CAP  = 1;
    localparam int CFG_BITS = 3;

    localparam int IRQ_LOCK = 0;
    localparam int IRQ_LOW  = 1;
    localparam int IRQ_UP   = 2;
    localparam int NUM_IRQ  = 3;
endpackage

// File: rtl/arx_bus_port.sv
// Module: single-word bus acknowledge generator.
// Assumes the master holds cyc/stb until it sees ack; ack is a one-cycle pulse.
module arx_bus_port (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc,
    input  logic stb,
    input  logic we,
    output logic ack,
    output logic acc,
    output logic wr_en
);
    // Accept a request only when no ack is in flight.
    assign acc   = cyc & stb & ~ack;
    assign wr_en = acc & we;

    // Acknowledge one cycle after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) ack <= 1'b0;
        else        ack <= acc;
    end
endmodule

// File: rtl/arx_lock_det.sv
// Module: lock synchronizer and rising-edge detector.
// Assumes lock_in may be asynchronous; one flop is used, and the edge is qualified by enable.
module arx_lock_det (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic lock_in,
    output logic locked,
    output logic lock_ev
);
    logic lock_q;
    logic locked_d;

    assign locked  = en & lock_q;
    assign lock_ev = locked & ~locked_d;

    // Register the raw lock and the previous qualified lock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q   <= 1'b0;
            locked_d <= 1'b0;
        end else begin
            lock_q   <= lock_in;
            locked_d <= locked;
        end
    end
endmodule

// File: rtl/arx_irq_ctrl.sv
// Module: interrupt mask, sticky flags with write-one-clear, level interrupt.
// Assumes events are single-cycle pulses; a set in the same cycle as a clear wins.
module arx_irq_ctrl #(
    parameter int W  = 16,
    parameter int NI = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  wdat,
    input  logic          mask_wr,
    input  logic          flag_wr,
    input  logic [NI-1:0] ev,
    output logic [W-1:0]  mask_q,
    output logic [W-1:0]  flag_q,
    output logic          irq
);
    localparam logic [W-1:0] SRC = W'((1 << NI) - 1);

    logic [W-1:0] ev_w;
    logic [W-1:0] clr;

    assign ev_w = W'(ev);
    assign clr  = flag_wr ? wdat : '0;
    assign irq  = |(flag_q & mask_q);

    // Hold the enable mask, written whole.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_wr) mask_q <= wdat & SRC;
    end

    // Clear flags written with one, then set flags with a pending event.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= ((flag_q & ~clr) | ev_w) & SRC;
    end
endmodule

// File: rtl/arx_sample_buf.sv
// Module: ping-pong sample store with a wrapping write pointer and half-full events.
// Assumes one store per strobe; the pointer rewinds whenever capture is off.
module arx_sample_buf #(
    parameter int W  = 16,
    parameter int IW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_en,
    input  logic          smp_valid,
    input  logic [W-1:0]  smp_data,
    input  logic [IW-1:0] rd_idx,
    output logic [W-1:0]  rd_word,
    output logic [IW-1:0] wr_ptr,
    output logic [1:0]    half_ev
);
    localparam int DEPTH = 1 << IW;
    localparam logic [IW-1:0] LOW_LAST = IW'(DEPTH / 2 - 1);
    localparam logic [IW-1:0] TOP_LAST = IW'(DEPTH - 1);

    logic [W-1:0] mem [DEPTH];
    logic         wr;

    assign wr      = cap_en & smp_valid;
    assign rd_word = mem[rd_idx];

    // Store the captured sample at the write pointer.
    always_ff @(posedge clk) begin
        if (wr) mem[wr_ptr] <= smp_data;
    end

    // Advance or rewind the pointer and flag completion of each half.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            half_ev <= '0;
        end else begin
            half_ev[0] <= wr && (wr_ptr == LOW_LAST);
            half_ev[1] <= wr && (wr_ptr == TOP_LAST);
            if (!cap_en)  wr_ptr <= '0;
            else if (wr)  wr_ptr <= wr_ptr + 1'b1;
        end
    end
endmodule

// File: rtl/audio_rx_regs.sv
// Module: top of the audio receiver control and interrupt register block.
// Assumes word offsets below half the space are registers; the upper half is the sample window.
module audio_rx_regs #(
    parameter int          DW      = 16,
    parameter int          AW      = 8,
    parameter logic [15:0] VERSION = 16'h0101
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_cyc,
    input  logic          bus_stb,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_adr,
    input  logic [DW-1:0] bus_wdat,
    output logic          bus_ack,
    output logic [DW-1:0] bus_rdat,
    output logic          irq,
    input  logic          lock_in,
    input  logic          smp_valid,
    input  logic [DW-1:0] smp_data
);
    import arx_pkg::*;

    localparam int IW = AW - 1;
    localparam logic [DW-1:0] CFG_MASK = DW'((1 << CFG_BITS) - 1);

    logic          acc, wr_en;
    logic [DW-1:0] cfg_q;
    logic [DW-1:0] mask_q, flag_q;
    logic          locked, lock_ev;
    logic [DW-1:0] rd_word;
    logic [IW-1:0] wr_ptr;
    logic [1:0]    half_ev;
    logic          cap_en;
    logic          in_win;
    logic [DW-1:0] rd_next;
    logic [NUM_IRQ-1:0] ev;

    assign in_win = bus_adr[AW-1];
    assign cap_en = cfg_q[CFG_EN] & cfg_q[CFG_CAP];
    assign ev     = {half_ev[1], half_ev[0], lock_ev};

    arx_bus_port u_bus (
        .clk(clk), .rst_n(rst_n), .cyc(bus_cyc), .stb(bus_stb), .we(bus_we),
        .ack(bus_ack), .acc(acc), .wr_en(wr_en)
    );

    arx_lock_det u_lock (
        .clk(clk), .rst_n(rst_n), .en(cfg_q[CFG_EN]), .lock_in(lock_in),
        .locked(locked), .lock_ev(lock_ev)
    );

    arx_irq_ctrl #(.W(DW), .NI(NUM_IRQ)) u_irq (
        .clk(clk), .rst_n(rst_n), .wdat(bus_wdat),
        .mask_wr(wr_en && !in_win && bus_adr == AW'(OFS_MASK)),
        .flag_wr(wr_en && !in_win && bus_adr == AW'(OFS_FLAG)),
        .ev(ev), .mask_q(mask_q), .flag_q(flag_q), .irq(irq)
    );

    arx_sample_buf #(.W(DW), .IW(IW)) u_buf (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .smp_valid(smp_valid),
        .smp_data(smp_data), .rd_idx(bus_adr[IW-1:0]), .rd_word(rd_word),
        .wr_ptr(wr_ptr), .half_ev(half_ev)
    );

    // Hold the configuration word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (wr_en && !in_win && bus_adr == AW'(OFS_CFG))
            cfg_q <= bus_wdat & CFG_MASK;
    end

    // Select the word that an access at the current offset returns.
    always_comb begin
        rd_next = '0;
        if (in_win) begin
            rd_next = rd_word;
        end else begin
            case (bus_adr)
                AW'(OFS_VER):  rd_next = DW'(VERSION);
                AW'(OFS_CFG):  rd_next = cfg_q;
                AW'(OFS_STAT): rd_next = DW'(locked);
                AW'(OFS_MASK): rd_next = mask_q;
                AW'(OFS_FLAG): rd_next = flag_q;
                default:       rd_next = '0;
            endcase
        end
    end

    // Register read data alongside the acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)   bus_rdat <= '0;
        else if (acc) bus_rdat <= rd_next;
    end
endmodule

// File: rtl/arx_regs_chk.sv
// Module: assertion checker for audio_rx_regs, attached by bind.
// Assumes access to the configuration enable, lock status, mask, capture enable and pointer.
module arx_regs_chk #(
    parameter int          DW      = 16,
    parameter int          AW      = 8,
    parameter logic [15:0] VERSION = 16'h0101
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_cyc,
    input logic          bus_stb,
    input logic          bus_we,
    input logic [AW-1:0] bus_adr,
    input logic          bus_ack,
    input logic [DW-1:0] bus_rdat,
    input logic          irq,
    input logic          cfg_en,
    input logic          locked,
    input logic [DW-1:0] mask_q,
    input logic          cap_en,
    input logic [AW-2:0] wr_ptr
);
    // R2: ack is a single-cycle pulse.
    p_ack_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);

    // R2: ack only follows a request.
    p_ack_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |-> $past(bus_cyc && bus_stb));

    // R1: a read of offset 0 returns the version.
    p_version_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ack && $past(!bus_we && bus_adr == '0)) |-> bus_rdat == DW'(VERSION));

    // R4: lock status needs the receiver enabled.
    p_lock_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |-> !locked);

    // R7: no mask bits, no interrupt.
    p_no_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq);

    // R10: pointer rewinds while capture is off.
    p_ptr_rewind_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> wr_ptr == '0);
endmodule

bind audio_rx_regs arx_regs_chk #(.DW(DW), .AW(AW), .VERSION(VERSION)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_cyc(bus_cyc), .bus_stb(bus_stb),
    .bus_we(bus_we), .bus_adr(bus_adr), .bus_ack(bus_ack), .bus_rdat(bus_rdat),
    .irq(irq), .cfg_en(cfg_q[0]), .locked(locked), .mask_q(mask_q),
    .cap_en(cap_en), .wr_ptr(wr_ptr)
);

// File: tb/sim_audio_rx_regs.sv
// Bench: table-driven register walk, then directed lock, capture, boundary and reset tests.
module sim_audio_rx_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_cyc = 1'b0, bus_stb = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_adr = '0;
    logic [15:0] bus_wdat = '0;
    logic        bus_ack;
    logic [15:0] bus_rdat;
    logic        irq;
    logic        lock_in = 1'b0;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_data = '0;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    audio_rx_regs u0 (
        .clk(clk), .rst_n(rst_n), .bus_cyc(bus_cyc), .bus_stb(bus_stb),
        .bus_we(bus_we), .bus_adr(bus_adr), .bus_wdat(bus_wdat),
        .bus_ack(bus_ack), .bus_rdat(bus_rdat), .irq(irq), .lock_in(lock_in),
        .smp_valid(smp_valid), .smp_data(smp_data)
    );

    // Table entry: {we, offset[7:0], wdata[15:0], expected[15:0]}; tag per entry.
    localparam int NT = 14;
    localparam logic [40:0] TBL [NT] = '{
        {1'b0, 8'h00, 16'h0000, 16'h0101},  // R1 version
        {1'b1, 8'h01, 16'h0005, 16'h0000},
        {1'b0, 8'h01, 16'h0000, 16'h0005},  // R3
        {1'b1, 8'h01, 16'hFFFF, 16'h0000},
        {1'b0, 8'h01, 16'h0000, 16'h0007},  // R3 upper bits dropped
        {1'b1, 8'h00, 16'h1234, 16'h0000},
        {1'b0, 8'h00, 16'h0000, 16'h0101},  // R11 version unchanged
        {1'b0, 8'h10, 16'h0000, 16'h0000},  // R11 unused offset
        {1'b1, 8'h03, 16'hFFFF, 16'h0000},
        {1'b0, 8'h03, 16'h0000, 16'h0007},  // R7 mask width
        {1'b1, 8'h03, 16'h0000, 16'h0000},
        {1'b0, 8'h02, 16'h0000, 16'h0000},  // R4 no lock yet
        {1'b1, 8'h01, 16'h0000, 16'h0000},
        {1'b0, 8'h01, 16'h0000, 16'h0000}   // R3 cleared
    };
    localparam int TAG [NT] = '{1, 3, 3, 3, 3, 11, 11, 11, 7, 7, 7, 4, 3, 3};

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One bus access; returns read data; checks the R2 ack pulse.
    task automatic access(input logic we, input logic [7:0] adr,
                          input logic [15:0] wd, output logic [15:0] rd);
        @(negedge clk);
        bus_cyc = 1'b1; bus_stb = 1'b1; bus_we = we; bus_adr = adr; bus_wdat = wd;
        @(negedge clk);
        check("R2 ack", {15'b0, bus_ack}, 16'h0001);
        rd = bus_rdat;
        bus_cyc = 1'b0; bus_stb = 1'b0; bus_we = 1'b0;
        @(negedge clk);
        check("R2 ack drop", {15'b0, bus_ack}, 16'h0000);
    endtask

    task automatic wr(input logic [7:0] adr, input logic [15:0] wd);
        logic [15:0] d;
        access(1'b1, adr, wd, d);
    endtask

    task automatic rd_chk(input string req, input logic [7:0] adr, input logic [15:0] exp);
        logic [15:0] d;
        access(1'b0, adr, 16'h0, d);
        check(req, d, exp);
    endtask

    task automatic push(input logic [15:0] v);
        @(negedge clk);
        smp_valid = 1'b1; smp_data = v;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R12 reset state
        check("R12 irq", {15'b0, irq}, 16'h0);
        check("R12 ack", {15'b0, bus_ack}, 16'h0);
        check("R12 rdat", bus_rdat, 16'h0);

        for (int i = 0; i < NT; i++) begin
            logic [15:0] d;
            access(TBL[i][40], TBL[i][39:32], TBL[i][31:16], d);
            if (!TBL[i][40]) check($sformatf("R%0d table %0d", TAG[i], i), d, TBL[i][15:0]);
        end

        // R4/R5: lock while masked
        wr(8'h01, 16'h0005);
        lock_in = 1'b1;
        idle(4);
        rd_chk("R4 status locked", 8'h02, 16'h0001);
        rd_chk("R5 flag set while masked", 8'h04, 16'h0001);
        check("R7 irq masked", {15'b0, irq}, 16'h0);
        wr(8'h03, 16'h0001);
        check("R5 irq on late mask", {15'b0, irq}, 16'h0001);
        wr(8'h04, 16'h0000);
        rd_chk("R6 zero write keeps flag", 8'h04, 16'h0001);
        check("R6 irq kept", {15'b0, irq}, 16'h0001);
        wr(8'h04, 16'h0001);
        rd_chk("R6 cleared", 8'h04, 16'h0000);
        check("R7 irq low after clear", {15'b0, irq}, 16'h0);
        wr(8'h02, 16'h0000);
        rd_chk("R11 status write ignored", 8'h02, 16'h0001);
        wr(8'h01, 16'h0000);
        rd_chk("R4 status disabled", 8'h02, 16'h0000);
        wr(8'h01, 16'h0005);
        idle(3);
        wr(8'h04, 16'h0007);

        // R8/R9: capture fill
        wr(8'h03, 16'h0007);
        wr(8'h01, 16'h0007);
        for (int i = 0; i < 63; i++) push(16'hA000 + 16'(i));
        idle(3);
        rd_chk("R9 no flag at 63", 8'h04, 16'h0000);
        push(16'hA000 + 16'd63);
        idle(3);
        check("R9 irq lower half", {15'b0, irq}, 16'h0001);
        rd_chk("R9 lower half flag", 8'h04, 16'h0002);
        wr(8'h04, 16'h0002);
        rd_chk("R8 entry 0", 8'h80, 16'hA000);
        rd_chk("R8 entry 63", 8'hBF, 16'hA03F);
        for (int i = 64; i < 127; i++) push(16'hA000 + 16'(i));
        idle(3);
        rd_chk("R9 no flag at 127", 8'h04, 16'h0000);
        push(16'hA07F);
        idle(3);
        rd_chk("R9 upper half flag", 8'h04, 16'h0004);
        wr(8'h04, 16'h0004);
        rd_chk("R8 entry 127", 8'hFF, 16'hA07F);

        // R10 wrap
        push(16'hBEEF);
        rd_chk("R10 wrap to entry 0", 8'h80, 16'hBEEF);
        rd_chk("R10 entry 1 intact", 8'h81, 16'hA001);

        // R8 capture off stores nothing; R10 rewind
        wr(8'h01, 16'h0005);
        push(16'h1111);
        rd_chk("R8 no store when off", 8'h80, 16'hBEEF);
        rd_chk("R8 entry 1 untouched", 8'h81, 16'hA001);
        wr(8'h01, 16'h0007);
        push(16'h2222);
        rd_chk("R10 rewind to entry 0", 8'h80, 16'h2222);
        rd_chk("R10 entry 1 after rewind", 8'h81, 16'hA001);

        // R11 window write ignored
        wr(8'h85, 16'h5555);
        rd_chk("R11 window write ignored", 8'h85, 16'hA005);

        // R12 mid-run reset
        @(negedge clk);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        check("R12 irq after reset", {15'b0, irq}, 16'h0);
        rd_chk("R12 cfg after reset", 8'h01, 16'h0000);
        rd_chk("R12 mask after reset", 8'h03, 16'h0000);
        rd_chk("R12 flags after reset", 8'h04, 16'h0000);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule